// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, per frame, whether the frame is kept. It watches the first six bytes of each frame (the destination address) as they stream in, one byte per accepted beat. It then produces one registered decision: a pass flag and a destination-filter-fail flag.

The decision combines several controls. Promiscuous acceptance and a receive-all override are two of them. Multicast frames can pass unconditionally, or through a 64-bit hash table indexed by a CRC of the address. Unicast (or any) addresses can also pass by exact match against a small table of programmed addresses, each of which has its own enable. Broadcast frames are always kept.

Configuration is level-driven by the surrounding register block. It is sampled in the cycle that carries the sixth address byte. The address table is loaded through a simple one-entry-per-cycle write port.

Top module: `rx_da_filter`

## Requirements
- R1: Address byte k (k = 0..5) is the k-th accepted byte after `sof_i`. The byte that carries `sof_i` is byte 0. The address value is {byte5,...,byte0}, so byte k sits in bits [8k+7:8k], and bit 0 is the group (multicast) bit. A new `sof_i` restarts capture, even in the middle of an address. Idle cycles between bytes are allowed. `dec_valid_o` is high in the cycle right after the clock edge that accepts byte 5.
- R2: `dec_valid_o` is a single-cycle pulse, one per captured address. `pass_o` and `da_fail_o` are 0 whenever `dec_valid_o` is 0. Bytes after byte 5 that arrive without `sof_i` have no effect.
- R3: With `promisc_i` set, every frame gives `pass_o`=1 and `da_fail_o`=0.
- R4: The all-ones (broadcast) address always passes.
- R5: With `pass_mcast_i` set, any address whose bit 0 is 1 passes.
- R6: The hash index is computed as follows. Run a reflected CRC-32 (polynomial 0xEDB88320, seed 0xFFFFFFFF) over bytes 0..5, least significant bit first. Invert the result, bit-reverse it, and keep the top 6 bits. Index bit 5 picks the word: 1 selects `hash_hi_i`, 0 selects `hash_lo_i`. Index bits 4:0 pick the bit within that word.
- R7: With `hash_en_i` set, a multicast address passes when the selected hash bit is 1. Both words all-ones therefore accept every multicast address, and both all-zeros accept none.
- R8: The table holds 16 entries. A write with `tbl_we_i` stores `tbl_mac_i` (same byte packing as R1) and `tbl_ena_i` into entry `tbl_idx_i`, effective from the next cycle. An address equal to an enabled entry passes.
- R9: An entry with its enable at 0 never matches.
- R10: With `rx_all_i` set, `pass_o`=1 for every frame. `da_fail_o` still reports 1 for addresses that would otherwise be rejected.
- R11: Without `rx_all_i`, a rejected address gives `pass_o`=0 and `da_fail_o`=1, and `da_fail_o` is always the inverse of `pass_o` on a decision.
- R12: While and after reset, and before any address is captured, `dec_valid_o`, `pass_o` and `da_fail_o` are 0, and all table entries are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Receive byte strobe |
| sof_i | input | 1 | Marks the first byte of a frame |
| byte_i | input | 8 | Receive byte |
| promisc_i | input | 1 | Accept every frame |
| rx_all_i | input | 1 | Forward every frame, keep fail reporting |
| pass_mcast_i | input | 1 | Accept every multicast address |
| hash_en_i | input | 1 | Enable multicast hash filtering |
| hash_lo_i | input | 32 | Hash word for index bit 5 = 0 |
| hash_hi_i | input | 32 | Hash word for index bit 5 = 1 |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 4 | Table entry to write |
| tbl_ena_i | input | 1 | Enable bit written with the entry |
| tbl_mac_i | input | 48 | Address written into the entry |
| dec_valid_o | output | 1 | Decision strobe |
| pass_o | output | 1 | Frame is kept |
| da_fail_o | output | 1 | Destination filter rejected the address |

## Verification
The sixth address byte is the only cycle in which the hash lookup, the table compare and the mode controls all meet. So the interesting collisions are a table write landing in that same cycle, and receive-all overlapping a rejected address. The bench checks that a table write becomes visible only to the frames that follow it. It also drives receive-all together with non-matching unicast and multicast addresses, and expects pass and fail both high. Random frames mix table hits, multicast, broadcast and random mode settings with idle gaps between bytes. Each decision is compared with a reference computed in the bench.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned MAC_W      = 8 * ADDR_BYTES;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  typedef struct packed {
    logic             en;
    logic [MAC_W-1:0] mac;
  } tbl_entry_t;

  // reflected CRC-32, one byte, LSB first
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_R;
    end
    return c;
  endfunction
endpackage

// File: rtl/da_crc_hash.sv
module da_crc_hash #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [7:0]       byte_i,
  output logic [IDX_W-1:0] idx_o
);
  import rx_da_filter_pkg::*;

  logic [31:0] crc_q, crc_base, crc_nxt;

  assign crc_base = start_i ? '1 : crc_q;
  assign crc_nxt  = crc_step(crc_base, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '1;
    else if (en_i) crc_q <= crc_nxt;
  end

  // top bits of bitrev(~crc) == reversed low bits of ~crc
  for (genvar k = 0; k < IDX_W; k++) begin : g_idx
    assign idx_o[IDX_W-1-k] = ~crc_nxt[k];
  end
endmodule

// File: rtl/da_addr_table.sv
module da_addr_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = $clog2(ENTRIES),
  parameter int unsigned MAC_W   = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wen_i,
  input  logic [MAC_W-1:0] wmac_i,
  input  logic [MAC_W-1:0] mac_i,
  output logic             hit_o
);
  import rx_da_filter_pkg::*;

  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    tbl_entry_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (we_i && widx_i == IDX_W'(e)) begin
        ent_q.en  <= wen_i;
        ent_q.mac <= wmac_i;
      end
    end
    assign match[e] = ent_q.en && (ent_q.mac == mac_i);
  end

  assign hit_o = |match;
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned TBL_IDX_W = $clog2(ENTRIES),
  parameter int unsigned HASH_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byte_valid_i,
  input  logic                 sof_i,
  input  logic [7:0]           byte_i,
  input  logic                 promisc_i,
  input  logic                 rx_all_i,
  input  logic                 pass_mcast_i,
  input  logic                 hash_en_i,
  input  logic [HASH_W-1:0]    hash_lo_i,
  input  logic [HASH_W-1:0]    hash_hi_i,
  input  logic                 tbl_we_i,
  input  logic [TBL_IDX_W-1:0] tbl_idx_i,
  input  logic                 tbl_ena_i,
  input  logic [47:0]          tbl_mac_i,
  output logic                 dec_valid_o,
  output logic                 pass_o,
  output logic                 da_fail_o
);
  import rx_da_filter_pkg::*;

  localparam int unsigned SEL_W  = $clog2(HASH_W);
  localparam int unsigned HIDX_W = SEL_W + 1;
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam int unsigned HOLD_W = 8 * (ADDR_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q, wr_pos;
  logic [HOLD_W-1:0] addr_q;
  logic [MAC_W-1:0]  full_mac;
  logic [HIDX_W-1:0] hash_idx;
  logic              take, last, hit, hash_bit, is_group, is_bcast, accept;
  logic              dec_q, pass_q, fail_q;

  // accept byte: new frame, or inside an unfinished address
  assign take   = byte_valid_i && (sof_i || (cnt_q != '0 && cnt_q < CNT_W'(ADDR_BYTES)));
  assign last   = take && !sof_i && (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign wr_pos = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (take) begin
      cnt_q <= wr_pos + CNT_W'(1);
      for (int k = 0; k < ADDR_BYTES - 1; k++) begin
        if (wr_pos == CNT_W'(k)) addr_q[8*k +: 8] <= byte_i;
      end
    end
  end

  assign full_mac = {byte_i, addr_q};

  da_crc_hash #(.IDX_W(HIDX_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (take),
    .start_i(sof_i),
    .byte_i (byte_i),
    .idx_o  (hash_idx)
  );

  da_addr_table #(.ENTRIES(ENTRIES), .IDX_W(TBL_IDX_W), .MAC_W(MAC_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .widx_i (tbl_idx_i),
    .wen_i  (tbl_ena_i),
    .wmac_i (tbl_mac_i),
    .mac_i  (full_mac),
    .hit_o  (hit)
  );

  assign hash_bit = hash_idx[SEL_W] ? hash_hi_i[hash_idx[SEL_W-1:0]]
                                    : hash_lo_i[hash_idx[SEL_W-1:0]];
  assign is_group = full_mac[0];
  assign is_bcast = &full_mac;
  assign accept   = promisc_i || is_bcast || hit ||
                    (is_group && (pass_mcast_i || (hash_en_i && hash_bit)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      dec_q  <= last;
      pass_q <= last && (accept || rx_all_i);
      fail_q <= last && !accept;
    end
  end

  assign dec_valid_o = dec_q;
  assign pass_o      = pass_q;
  assign da_fail_o   = fail_q;
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_valid_i,
  input logic sof_i,
  input logic promisc_i,
  input logic rx_all_i,
  input logic dec_valid_o,
  input logic pass_o,
  input logic da_fail_o
);
  // R1
  dec_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(byte_valid_i) && !$past(sof_i));

  // R2
  dec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> !pass_o && !da_fail_o);

  // R3
  promisc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && $past(promisc_i) |-> pass_o && !da_fail_o);

  // R10
  rx_all_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && $past(rx_all_i) |-> pass_o);

  // R11
  fail_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !$past(rx_all_i) |-> pass_o != da_fail_o);
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (.*);

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0, sof = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        promisc = 0, rx_all = 0, pass_mcast = 0, hash_en = 0;
  logic [31:0] hash_lo = '0, hash_hi = '0;
  logic        tbl_we = 0, tbl_ena = 0;
  logic [3:0]  tbl_idx = '0;
  logic [47:0] tbl_mac = '0;
  logic        dec_valid, pass_w, fail_w;

  int checks = 0, errors = 0;
  bit          ref_en [16];
  logic [47:0] ref_mac [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_da_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .sof_i(sof), .byte_i(byte_d),
    .promisc_i(promisc), .rx_all_i(rx_all), .pass_mcast_i(pass_mcast), .hash_en_i(hash_en),
    .hash_lo_i(hash_lo), .hash_hi_i(hash_hi), .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx),
    .tbl_ena_i(tbl_ena), .tbl_mac_i(tbl_mac), .dec_valid_o(dec_valid), .pass_o(pass_w),
    .da_fail_o(fail_w)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int ref_hidx(input logic [47:0] mac);
    logic [31:0] c = '1, r;
    bit fb;
    for (int b = 0; b < 48; b++) begin
      fb = c[0] ^ mac[b];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    c = ~c;
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return int'(r[31:26]);
  endfunction

  function automatic bit ref_accept(input logic [47:0] mac);
    int h;
    bit hb;
    if (promisc || (&mac)) return 1;
    for (int e = 0; e < 16; e++) if (ref_en[e] && ref_mac[e] == mac) return 1;
    h  = ref_hidx(mac);
    hb = (h >= 32) ? hash_hi[h-32] : hash_lo[h];
    return mac[0] && (pass_mcast || (hash_en && hb));
  endfunction

  task automatic twrite(input int idx, input bit en, input logic [47:0] mac);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_ena = en; tbl_mac = mac;
    @(negedge clk);
    tbl_we = 0;
    ref_en[idx] = en; ref_mac[idx] = mac;
  endtask

  task automatic send_frame(input logic [47:0] mac, input bit gaps, input string tag);
    bit acc;
    acc = ref_accept(mac);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) begin
        byte_valid = 0; sof = 0;
        @(negedge clk);
        chk(32'(dec_valid), 0, "R2 early");
      end
      byte_valid = 1; sof = (k == 0); byte_d = mac[8*k +: 8];
    end
    @(negedge clk);
    byte_valid = 0; sof = 0;
    chk(32'(dec_valid), 1, {tag, " R1 valid"});
    chk(32'(pass_w), 32'(acc | rx_all), {tag, " pass"});
    chk(32'(fail_w), 32'(!acc), {tag, " fail"});
    @(negedge clk);
    chk(32'(dec_valid), 0, "R2 pulse");
    chk(32'(pass_w | fail_w), 0, "R2 quiet");
  endtask

  function automatic logic [47:0] rnd_mac();
    return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] a, b, m;
    int h;
    void'($urandom(32'd20240611));
    for (int e = 0; e < 16; e++) begin ref_en[e] = 0; ref_mac[e] = '0; end
    repeat (3) @(negedge clk);
    chk(32'({dec_valid, pass_w, fail_w}), 0, "R12 in reset");
    rst_n = 1;
    @(negedge clk);
    chk(32'({dec_valid, pass_w, fail_w}), 0, "R12 after reset");

    a = 48'h6655_4433_2210;               // unicast, bit0 = 0
    send_frame(a, 0, "R11 unicast no match");
    send_frame(48'hFFFF_FFFF_FFFF, 0, "R4 broadcast");
    promisc = 1;
    send_frame(a, 0, "R3 promisc");
    promisc = 0;

    twrite(3, 1, a);
    send_frame(a, 0, "R8 table hit");
    send_frame(a ^ 48'h0000_0000_0100, 0, "R8 near miss");
    b = 48'h0102_0304_0500;
    twrite(15, 0, b);
    send_frame(b, 0, "R9 disabled entry");
    twrite(15, 1, b);
    send_frame(b, 1, "R8 enabled entry");

    // table write landing in the sixth-byte cycle: old contents apply
    m = 48'hA1B2_C3D4_E5F0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byte_valid = 1; sof = (k == 0); byte_d = m[8*k +: 8];
      if (k == 5) begin tbl_we = 1; tbl_idx = 4'd7; tbl_ena = 1; tbl_mac = m; end
    end
    @(negedge clk);
    byte_valid = 0; tbl_we = 0;
    chk(32'({dec_valid, pass_w, fail_w}), 3'b101, "R8 write same cycle");
    ref_en[7] = 1; ref_mac[7] = m;
    send_frame(m, 0, "R8 write visible after");

    m = 48'h1234_5678_9A01;               // multicast
    hash_en = 1; hash_lo = '0; hash_hi = '0;
    send_frame(m, 0, "R7 hash empty");
    h = ref_hidx(m);
    if (h >= 32) hash_hi[h-32] = 1'b1; else hash_lo[h] = 1'b1;
    send_frame(m, 0, "R6 hash bit set");
    hash_lo = ~hash_lo; hash_hi = ~hash_hi;
    send_frame(m, 0, "R6 all but selected");
    hash_lo = '1; hash_hi = '1;
    send_frame(m ^ 48'h0F0F_0000_0000, 0, "R7 all ones");
    hash_en = 0; hash_lo = '0; hash_hi = '0;
    send_frame(m, 0, "R5 mcast off");
    pass_mcast = 1;
    send_frame(m, 0, "R5 pass mcast");
    pass_mcast = 0;

    rx_all = 1;
    send_frame(48'h9999_8888_7776, 0, "R10 reject forwarded");
    send_frame(m, 0, "R10 mcast reject forwarded");
    send_frame(a, 0, "R10 hit");
    rx_all = 0;

    // restart mid address
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      byte_valid = 1; sof = (k == 0); byte_d = 8'hEE;
    end
    send_frame(a, 0, "R1 restart");
    // trailing bytes without sof
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      byte_valid = 1; sof = 0; byte_d = 8'hFF;
      chk(32'(dec_valid), 0, "R2 trailing bytes");
    end
    @(negedge clk);
    byte_valid = 0;
    chk(32'(dec_valid), 0, "R2 trailing bytes");

    for (int n = 0; n < 200; n++) begin
      int sel;
      promisc    = ($urandom % 8 == 0);
      rx_all     = ($urandom % 6 == 0);
      pass_mcast = ($urandom % 5 == 0);
      hash_en    = ($urandom % 2 == 0);
      hash_lo    = $urandom; hash_hi = $urandom;
      if ($urandom % 10 == 0) twrite(int'($urandom % 16), bit'($urandom % 2), rnd_mac());
      sel = int'($urandom % 4);
      case (sel)
        0: a = ref_mac[$urandom % 16];
        1: a = rnd_mac() | 48'h1;
        2: a = ($urandom % 4 == 0) ? 48'hFFFF_FFFF_FFFF : rnd_mac();
        default: a = rnd_mac() & ~48'h1;
      endcase
      send_frame(a, 1, "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule